// File: doc/BRIEF.md
# Ethernet Transmit Framer with Minimum-Size Padding

This block takes one frame at a time from a client byte stream and turns it into the byte sequence that goes onto the line. The client supplies the frame body, starting with the destination address and ending with the last payload byte. The block adds the seven-byte preamble and the start delimiter in front of the body. It fills short frames with zero bytes up to the legal minimum and appends the 32-bit frame check sequence. After every frame it holds the line idle for the inter-packet gap.

The client side is a valid/ready stream with a last flag. A byte moves on a clock edge where both `in_valid` and `in_ready` are high. Ready is high only while the block is copying frame bytes. It is low during the preamble, padding, check sequence and gap, so the client stalls there. Once the first byte of a frame is offered, the client must keep `in_valid` high until the byte flagged last has been accepted. A gap in the client stream inside a frame shows up as an idle byte on the line. The line side has no back-pressure: `out_valid` marks each byte time that carries a byte.

A station-address mode replaces the six source-address bytes with a programmed 48-bit address before the check sequence is computed. Frames longer than the maximum are cut short, and the overflow bytes are taken from the client and dropped.

Top module: `eth_tx_framer`

## Requirements
- R1: Every frame on the line opens with seven 0x55 bytes followed by one 0xD5 byte.
- R2: After the delimiter, the client bytes appear unchanged and in arrival order, destination address first. When insertion is disabled this includes bytes 6 to 11.
- R3: An untagged frame is padded with 0x00 bytes after the last client byte. Padding continues until the payload that follows the 14-byte header reaches 46 bytes. The line frame is therefore at least 64 bytes, counted without preamble and delimiter.
- R4: A frame whose bytes 12 and 13 are 0x81 and 0x00 is treated as tagged. Its payload, which follows an 18-byte header, is padded to 42 bytes.
- R5: When `addr_ins_en` is high, client bytes at positions 6 to 11 are replaced by `station_addr`, sending bits [47:40] first and [7:0] last. Only positions that the client actually supplied are replaced.
- R6: Four check-sequence bytes follow the body and padding. They hold the CRC-32 of the sent body: reflected polynomial 0x04C11DB7, start value all ones, result complemented, least significant byte first. A reflected CRC taken over the body plus these four bytes therefore leaves the residue 0xDEBB20E3.
- R7: At most 1514 body bytes are sent, giving a 1518-byte frame. When a client frame is longer, the check sequence follows byte 1514. The rest of the client frame, up to and including the last byte, is then accepted and discarded.
- R8: After the final check-sequence byte, `out_valid` stays low for at least 12 cycles. When the next frame is already waiting, the gap is exactly 12 cycles.
- R9: `in_ready` is high only while client bytes are being taken: during body copy and during the discard phase of R7. For a client that holds valid through a frame, the number of ready-high cycles equals the frame's byte count.
- R10: While and after reset, until a frame is offered, `out_valid` and `in_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one byte time per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_ins_en | input | 1 | Replace the source address with `station_addr`; hold it steady within a frame |
| station_addr | input | 48 | Programmed station address, first byte on the line in [47:40] |
| in_valid | input | 1 | Client byte valid |
| in_data | input | 8 | Client byte |
| in_last | input | 1 | Marks the last client byte of the frame |
| in_ready | output | 1 | Block takes the client byte on this edge |
| out_valid | output | 1 | Line byte present |
| out_data | output | 8 | Line byte |

## Verification
Every frame length is swept from one byte to well past the padding boundary, tagged and untagged, with insertion on and off. The bench goes after several corner cases. Frames that end exactly at 60 body bytes show whether the pad decision is off by one: a wrong design would send one byte too many or too few. Frames shorter than the source-address field show whether insertion leaks into the padding. The boundary lengths 1514 and 1515, plus a far oversize frame, show whether truncation cuts in the wrong place or forgets to drain the client. A wrong design would lose frame alignment on the following frame. The CRC is judged by its residue, so a wrong byte order or a missing complement shows up at once. A back-to-back pair measures the gap exactly, which catches a counter that ends one cycle early.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_BODY,
    ST_PAD,
    ST_FCS,
    ST_DRAIN,
    ST_GAP
  } tx_state_e;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [7:0]  BYTE_PRE      = 8'h55;
  localparam logic [7:0]  BYTE_SFD      = 8'hD5;

  // One byte of the reflected CRC-32, least significant bit first.
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/eth_tx_crc.sv
module eth_tx_crc
  import eth_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        en,
  input  logic [7:0]  data,
  output logic [31:0] crc_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    crc_q <= '1;
    else if (init) crc_q <= '1;
    else if (en)   crc_q <= crc32_step(crc_q, data);
  end

endmodule

// File: rtl/eth_tx_srcsub.sv
module eth_tx_srcsub #(
  parameter int CW = 11
) (
  input  logic          ins_en,
  input  logic [47:0]   station_addr,
  input  logic [CW-1:0] idx,
  input  logic [7:0]    data_in,
  output logic [7:0]    data_out
);

  // Source address occupies body positions 6..11.
  always_comb begin
    data_out = data_in;
    for (int j = 0; j < 6; j++) begin
      if (ins_en && idx == CW'(6 + j)) data_out = station_addr[8*(5-j) +: 8];
    end
  end

endmodule

// File: rtl/eth_tx_seq.sv
module eth_tx_seq
  import eth_tx_pkg::*;
#(
  parameter int PRE_LEN          = 7,
  parameter int MIN_FRAME        = 64,
  parameter int MAX_FRAME        = 1518,
  parameter int IPG_BYTES        = 12,
  parameter int MIN_PAYLOAD_VLAN = 42,
  parameter int CW               = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_last,
  input  logic [7:0]    byte_in,
  output logic          in_ready,
  output logic [CW-1:0] byte_idx,
  input  logic [31:0]   crc_q,
  output logic          crc_init,
  output logic          crc_en,
  output logic [7:0]    crc_byte,
  output logic          out_valid,
  output logic [7:0]    out_data
);

  localparam int SW = $clog2(((IPG_BYTES > PRE_LEN) ? IPG_BYTES : PRE_LEN) + 1);
  localparam logic [SW-1:0] PRE_LAST = SW'(PRE_LEN);
  localparam logic [SW-1:0] GAP_LAST = SW'(IPG_BYTES - 1);
  localparam logic [SW-1:0] FCS_LAST = SW'(3);
  localparam logic [CW-1:0] BODY_MAX   = CW'(MAX_FRAME - 4);
  localparam logic [CW-1:0] MIN_PLAIN  = CW'(MIN_FRAME - 4);
  localparam logic [CW-1:0] MIN_TAGGED = CW'(18 + MIN_PAYLOAD_VLAN);
  localparam logic [CW-1:0] IDX_TAG_HI = CW'(12);
  localparam logic [CW-1:0] IDX_TAG_LO = CW'(13);

  tx_state_e     state_q;
  logic [CW-1:0] n_q, n_inc, min_total;
  logic [SW-1:0] sub_q;
  logic          tag_hi_q, tagged_q, trunc_q, tag_now;
  logic [31:0]   fcs_word;
  logic [7:0]    fcs_byte;

  assign byte_idx = n_q;
  assign n_inc    = n_q + 1'b1;
  assign in_ready = (state_q == ST_BODY) || (state_q == ST_DRAIN);

  always_comb begin
    tag_now   = tagged_q ||
                (state_q == ST_BODY && n_q == IDX_TAG_LO && tag_hi_q && byte_in == 8'h00);
    min_total = tag_now ? MIN_TAGGED : MIN_PLAIN;
    crc_init  = (state_q == ST_PRE) && (sub_q == PRE_LAST);
    crc_en    = ((state_q == ST_BODY) && in_valid) || (state_q == ST_PAD);
    crc_byte  = (state_q == ST_PAD) ? 8'h00 : byte_in;
    fcs_word  = ~crc_q;
    case (sub_q[1:0])
      2'd0:    fcs_byte = fcs_word[7:0];
      2'd1:    fcs_byte = fcs_word[15:8];
      2'd2:    fcs_byte = fcs_word[23:16];
      default: fcs_byte = fcs_word[31:24];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      n_q       <= '0;
      sub_q     <= '0;
      tag_hi_q  <= 1'b0;
      tagged_q  <= 1'b0;
      trunc_q   <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          out_valid <= 1'b0;
          if (in_valid) begin
            out_valid <= 1'b1;
            out_data  <= BYTE_PRE;
            sub_q     <= SW'(1);
            state_q   <= ST_PRE;
          end
        end
        ST_PRE: begin
          out_valid <= 1'b1;
          if (sub_q == PRE_LAST) begin
            out_data <= BYTE_SFD;
            n_q      <= '0;
            tag_hi_q <= 1'b0;
            tagged_q <= 1'b0;
            trunc_q  <= 1'b0;
            state_q  <= ST_BODY;
          end else begin
            out_data <= BYTE_PRE;
            sub_q    <= sub_q + 1'b1;
          end
        end
        ST_BODY: begin
          out_valid <= in_valid;
          if (in_valid) begin
            out_data <= byte_in;
            n_q      <= n_inc;
            if (n_q == IDX_TAG_HI) tag_hi_q <= (byte_in == 8'h81);
            if (tag_now)           tagged_q <= 1'b1;
            if (in_last) begin
              if (n_inc < min_total) state_q <= ST_PAD;
              else begin
                state_q <= ST_FCS;
                sub_q   <= '0;
              end
            end else if (n_inc == BODY_MAX) begin
              trunc_q <= 1'b1;
              state_q <= ST_FCS;
              sub_q   <= '0;
            end
          end
        end
        ST_PAD: begin
          out_valid <= 1'b1;
          out_data  <= 8'h00;
          n_q       <= n_inc;
          if (n_inc == min_total) begin
            state_q <= ST_FCS;
            sub_q   <= '0;
          end
        end
        ST_FCS: begin
          out_valid <= 1'b1;
          out_data  <= fcs_byte;
          sub_q     <= sub_q + 1'b1;
          if (sub_q == FCS_LAST) begin
            sub_q   <= '0;
            state_q <= trunc_q ? ST_DRAIN : ST_GAP;
          end
        end
        ST_DRAIN: begin
          out_valid <= 1'b0;
          if (in_valid && in_last) begin
            trunc_q <= 1'b0;
            sub_q   <= '0;
            state_q <= ST_GAP;
          end
        end
        ST_GAP: begin
          out_valid <= 1'b0;
          sub_q     <= sub_q + 1'b1;
          if (sub_q == GAP_LAST) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer #(
  parameter int PRE_LEN          = 7,
  parameter int MIN_FRAME        = 64,
  parameter int MAX_FRAME        = 1518,
  parameter int IPG_BYTES        = 12,
  parameter int MIN_PAYLOAD_VLAN = 42
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        addr_ins_en,
  input  logic [47:0] station_addr,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  output logic        in_ready,
  output logic        out_valid,
  output logic [7:0]  out_data
);

  localparam int CW = $clog2(MAX_FRAME + 1);

  logic [CW-1:0] byte_idx;
  logic [7:0]    sub_byte, crc_byte;
  logic [31:0]   crc_q;
  logic          crc_init, crc_en;

  eth_tx_srcsub #(.CW(CW)) u_srcsub (
    .ins_en       (addr_ins_en),
    .station_addr (station_addr),
    .idx          (byte_idx),
    .data_in      (in_data),
    .data_out     (sub_byte)
  );

  eth_tx_crc u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .init  (crc_init),
    .en    (crc_en),
    .data  (crc_byte),
    .crc_q (crc_q)
  );

  eth_tx_seq #(
    .PRE_LEN          (PRE_LEN),
    .MIN_FRAME        (MIN_FRAME),
    .MAX_FRAME        (MAX_FRAME),
    .IPG_BYTES        (IPG_BYTES),
    .MIN_PAYLOAD_VLAN (MIN_PAYLOAD_VLAN),
    .CW               (CW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .byte_in   (sub_byte),
    .in_ready  (in_ready),
    .byte_idx  (byte_idx),
    .crc_q     (crc_q),
    .crc_init  (crc_init),
    .crc_en    (crc_en),
    .crc_byte  (crc_byte),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

endmodule

// File: rtl/eth_tx_framer_chk.sv
module eth_tx_framer_chk #(
  parameter int PRE_LEN   = 7,
  parameter int MIN_FRAME = 64,
  parameter int MAX_FRAME = 1518,
  parameter int IPG_BYTES = 12
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic [7:0] out_data
);

  localparam logic [15:0] PRE_L  = 16'(PRE_LEN);
  localparam logic [15:0] FR_MIN = 16'(PRE_LEN + 1 + MIN_FRAME);
  localparam logic [15:0] FR_MAX = 16'(PRE_LEN + 1 + MAX_FRAME);
  localparam logic [7:0]  GAP_MIN = 8'(IPG_BYTES);

  logic [15:0] run_len;
  logic [7:0]  idle_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_len  <= '0;
      idle_len <= 8'hFF;
    end else begin
      run_len  <= out_valid ? ((run_len == 16'hFFFF) ? run_len : run_len + 1'b1) : '0;
      idle_len <= out_valid ? '0 : ((idle_len == 8'hFF) ? idle_len : idle_len + 1'b1);
    end
  end

  AST_PREAMBLE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && run_len < PRE_L) |-> out_data == 8'h55); // R1
  AST_DELIM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && run_len == PRE_L) |-> out_data == 8'hD5); // R1
  AST_FRAME_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && run_len != 0) |-> (run_len >= FR_MIN && run_len <= FR_MAX)); // R3
  AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && idle_len != 0) |-> idle_len >= GAP_MIN); // R8
  AST_NO_READY_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && run_len < PRE_L) |-> !in_ready); // R9

endmodule

bind eth_tx_framer eth_tx_framer_chk #(
  .PRE_LEN   (PRE_LEN),
  .MIN_FRAME (MIN_FRAME),
  .MAX_FRAME (MAX_FRAME),
  .IPG_BYTES (IPG_BYTES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/eth_tx_framer_tb.sv
module eth_tx_framer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BODY_MAX   = 1514;
  localparam int BODY_MIN   = 60;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_ins_en = 1'b0;
  logic [47:0] station_addr = 48'h02A1B2C3D4E5;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        in_ready, out_valid;
  logic [7:0]  out_data;

  eth_tx_framer u_dut (
    .clk (clk), .rst_n (rst_n), .addr_ins_en (addr_ins_en), .station_addr (station_addr),
    .in_valid (in_valid), .in_data (in_data), .in_last (in_last), .in_ready (in_ready),
    .out_valid (out_valid), .out_data (out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  int frames_seen = 0, exp_frames = 0;
  int idle_cnt = 1000, start_gap = 0, last_gap = 0, rdy_cnt = 0;
  logic [7:0] cap[$];
  logic [7:0] got[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (in_ready) rdy_cnt++;
      if (out_valid) begin
        if (cap.size() == 0) start_gap = idle_cnt;
        cap.push_back(out_data);
        idle_cnt = 0;
      end else begin
        if (cap.size() > 0) begin
          got = cap;
          cap = {};
          last_gap = start_gap;
          frames_seen++;
        end
        idle_cnt++;
      end
    end
  end

  function automatic logic [31:0] residue(input logic [7:0] q[$]);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 8; i < q.size(); i++)
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ q[i][b];
        c = {1'b0, c[31:1]};
        if (fb) c = c ^ 32'hEDB88320;
      end
    return c;
  endfunction

  task automatic run_frame(input int len, input bit tag, input bit ins,
                           input int seed, input bit check);
    logic [7:0] cl[$];
    logic [7:0] body[$];
    int exp_len, mism;
    string req;
    for (int i = 0; i < len; i++) begin
      logic [7:0] b = 8'(i * 29 + seed * 7 + 3);
      if (i == 12) b = tag ? 8'h81 : 8'h08;
      if (i == 13) b = tag ? 8'h00 : 8'h06;
      cl.push_back(b);
    end
    addr_ins_en = ins;
    rdy_cnt = 0;
    exp_frames++;
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1;
      in_data  = cl[i];
      in_last  = (i == len - 1);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    if (!check) return;
    wait (frames_seen == exp_frames);
    for (int i = 0; i < len && i < BODY_MAX; i++)
      body.push_back((ins && i >= 6 && i <= 11) ? station_addr[8*(11-i) +: 8] : cl[i]);
    while (body.size() < BODY_MIN) body.push_back(8'h00);
    exp_len = 8 + body.size() + 4;
    req = (len > BODY_MAX) ? "R7" : (tag ? "R4" : "R3");
    chk(got.size() == exp_len, req, $sformatf("line length len=%0d", len), got.size(), exp_len);
    if (got.size() == exp_len) begin
      mism = -1;
      for (int i = 0; i < 7; i++) if (got[i] != 8'h55) mism = i;
      if (got[7] != 8'hD5) mism = 7;
      chk(mism < 0, "R1", "preamble/delimiter position", mism, -1);
      mism = -1;
      for (int i = 0; i < body.size(); i++)
        if (mism < 0 && got[8+i] != body[i]) mism = i;
      req = ins ? "R5" : "R2";
      chk(mism < 0, req, $sformatf("body byte index len=%0d", len), mism, -1);
      chk(residue(got) == 32'hDEBB20E3, "R6", "fcs residue", residue(got), 32'hDEBB20E3);
    end
    chk(rdy_cnt == len, "R9", "ready-high cycles", rdy_cnt, len);
    chk(last_gap >= 12, "R8", "idle before frame", last_gap, 12);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !in_ready, "R10", "reset outputs", {out_valid, in_ready}, 0);
    for (int ins = 0; ins < 2; ins++) begin
      for (int len = 1; len <= 70; len++) run_frame(len, 1'b0, ins[0], len, 1'b1);
      for (int len = 14; len <= 70; len++) run_frame(len, 1'b1, ins[0], len + 3, 1'b1);
    end
    run_frame(BODY_MAX, 1'b0, 1'b1, 5, 1'b1);      // R7 boundary, no cut
    run_frame(BODY_MAX + 1, 1'b0, 1'b0, 6, 1'b1);  // R7 one over
    run_frame(1600, 1'b1, 1'b0, 7, 1'b1);          // R7 far over
    run_frame(61, 1'b0, 1'b0, 8, 1'b1);            // alignment after drain
    run_frame(70, 1'b0, 1'b0, 9, 1'b0);
    run_frame(80, 1'b1, 1'b1, 10, 1'b1);
    chk(last_gap == 12, "R8", "back-to-back gap", last_gap, 12);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R8 act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule